// File: doc/BRIEF.md
# Three-Wire Transceiver Control Slave

This block sits on the transceiver side of a three-wire control bus. The bus clock is a slow strobe from the controller. Write data shares the transmit-data pin, and read data shares the receive-data pin. The block samples all of them with its own fast clock. It has no control mode after reset. To enter control mode, the controller clocks the bus many times with the write line held low. After that, each transaction is framed on the bus clock as follows:

1. An announcing rising edge.
2. A start cycle.
3. A command byte.
4. Further bytes, each one preceded by its own start cycle.

Writes update three configuration registers. These control sleep/awake, receive enable, transmit enable, a rate register and a power-level field. Reads return one of these registers or a fixed identity byte. The block shifts the returned byte out on the shared read pin. While a transaction runs, the block blanks the light emitter, because the write data would otherwise flash it. During its own response it also masks the photodetector, so that stray light cannot corrupt the reply. Outside a response, the read pin passes the raw detector output, gated by the configuration. The emitter output follows the transmit pin, gated by the configuration and by the blanking flag.

Top module: `xcvr_ctl_slave`

## Requirements
- R1: Control mode begins on the 30th consecutive bus-clock rising edge that samples the write line low. A rising edge that samples it high restarts the count. Before control mode, no transaction is recognised, and the emitter blank flag stays low.
- R2: In control mode, a rising edge while idle announces a transaction and raises the emitter blank flag. The next rising edge is the start cycle. The flag drops on the last rising edge of the transaction.
- R3: Bytes travel least significant bit first, sampled on bus-clock rising edges, with no gap between them. Each byte follows its own start cycle. In the command byte, bits [2:0] are the device address, bits [6:3] the index, and bit 7 the direction, where 1 = write and 0 = read.
- R4: A write is a command byte plus a data byte. Index 0 sets the mode register (bit 0 awake, bit 1 receive enable, bit 2 transmit enable). Index 1 stores the whole byte as the rate register, and bit 0 of it selects the fast rate. Index 2 stores bits [7:6] as the power level. Writes to any other index change nothing.
- R5: After reset the block is asleep, receive and transmit are disabled, the rate register is 0x00 and the power level is 2'b11. Control mode is off.
- R6: For a read, the bus clock gives a start cycle after the command byte. The block then drives the 8 response bits on successive rising edges, least significant first. Readback values:
  - Index 0 returns {5'b0, transmit enable, receive enable, awake}.
  - Index 1 returns the rate register.
  - Index 2 returns {power, 6'b0}.
  - Unused indexes return 0x00.
- R7: Index 4'hF selects the extended form, in which byte 2 is an extended index. A read returns 0x01 for extended index 0 and 0x41 for extended index 1, and 0x00 for any other extended index. An extended write carries a third byte and changes nothing.
- R8: A read ends on the first response rising edge where the write line is sampled low after having been sampled high on the previous rising edge. The block drives its response bit on that edge too. It releases the read pin and the detector mask on the next bus-clock falling edge.
- R9: For an addressed read, the detector mask rises on the start cycle just before the response. It stays high until the release in R8.
- R10: A command whose address is not 3'b000 is framed normally but is ignored. No register changes, no response bit is driven, and the detector mask stays low.
- R11: When no response is being driven, the read pin is high while the detector mask is set, receive is disabled, or the block is asleep. Otherwise the read pin follows the active-low detector input.
- R12: The emitter output is the transmit pin ANDed with transmit enable, with awake, and with the inverse of the blank flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Bus clock from the controller |
| txd_swdat_i | input | 1 | Transmit data / serial write data |
| det_rx_n_i | input | 1 | Raw photodetector output, active low |
| rxd_srdat_o | output | 1 | Receive data / serial read data |
| led_drive_o | output | 1 | Emitter drive |
| led_blank_o | output | 1 | Emitter blank flag |
| det_blank_o | output | 1 | Detector mask flag |
| ctl_mode_o | output | 1 | Control mode reached |
| awake_o | output | 1 | Mode register: awake |
| rx_en_o | output | 1 | Mode register: receive enable |
| tx_en_o | output | 1 | Mode register: transmit enable |
| fast_rate_o | output | 1 | Rate register bit 0 |
| power_lvl_o | output | 2 | Power level (00 = 10%, 01 = 25%, 10 = 50%, 11 = 100%) |

## Verification
A framing counter that is off by one shows up as a byte misaligned by one bit. A readback byte then arrives shifted or doubled within the same transaction, and the gating outputs change a whole bus-clock period early or late. A corrupted configuration register appears at the configuration pins three local clocks after the offending rising edge. It also appears at once in how the emitter and read pins respond to the transmit and detector inputs. A lost release or end-marker decision leaves the blank or mask flag high into idle, and the comparison catches this at the first idle clock.

// File: rtl/xcvr_ctl_pkg.sv
package xcvr_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = 4;

    localparam logic [IDX_W-1:0] IDX_MODE  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_RATE  = 4'd1;
    localparam logic [IDX_W-1:0] IDX_POWER = 4'd2;
    localparam logic [IDX_W-1:0] IDX_EXT   = 4'hF;

    typedef enum logic [2:0] {
        F_IDLE, F_PEND, F_CMD, F_GAP2, F_BYTE2, F_GAP3, F_BYTE3, F_RESP
    } frame_st_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             wr;
        logic             ext;
        logic             hit;
    } cmd_t;

    typedef struct packed {
        logic              awake;
        logic              rx_en;
        logic              tx_en;
        logic [BYTE_W-1:0] rate;
        logic [1:0]        power;
    } cfg_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b,
                                        input logic [ADDR_W-1:0] own);
        cmd_t c;
        c.idx = b[ADDR_W +: IDX_W];
        c.wr  = b[BYTE_W-1];
        c.ext = (b[ADDR_W +: IDX_W] == IDX_EXT);
        c.hit = (b[ADDR_W-1:0] == own);
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] read_value(input cfg_t c,
                                                     input logic [IDX_W-1:0] idx,
                                                     input logic [BYTE_W-1:0] eidx,
                                                     input logic [BYTE_W-1:0] mfr,
                                                     input logic [BYTE_W-1:0] prod);
        logic [BYTE_W-1:0] v;
        case (idx)
            IDX_MODE:  v = {5'b0, c.tx_en, c.rx_en, c.awake};
            IDX_RATE:  v = c.rate;
            IDX_POWER: v = {c.power, 6'b0};
            IDX_EXT: begin
                if (eidx == 8'd0)      v = mfr;
                else if (eidx == 8'd1) v = prod;
                else                   v = '0;
            end
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/xcvr_ctl_sync.sv
module xcvr_ctl_sync #(
    parameter int STAGES = 2,
    parameter int DW     = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_clk_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_q,
    output logic          rise_o,
    output logic          fall_o
);
    localparam int LW = DW + 1;

    logic [LW-1:0] stg [STAGES];
    logic          clk_prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= {data_i, bus_clk_i};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b0;
        else     clk_prev <= stg[STAGES-1][0];
    end

    assign data_q = stg[STAGES-1][LW-1:1];
    assign rise_o = stg[STAGES-1][0] & ~clk_prev;
    assign fall_o = ~stg[STAGES-1][0] & clk_prev;

endmodule

// File: rtl/xcvr_ctl_frame.sv
module xcvr_ctl_frame
    import xcvr_ctl_pkg::*;
#(
    parameter int                INIT_EDGES = 30,
    parameter logic [ADDR_W-1:0] DEV_ADDR   = 3'b000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              sw,
    input  logic [BYTE_W-1:0] rd_data,
    output cmd_t              cmd_q,
    output logic [BYTE_W-1:0] eidx_q,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              mode,
    output logic              led_blank,
    output logic              det_blank,
    output logic              drive,
    output logic              sbit
);
    localparam int CNT_W = $clog2(INIT_EDGES + 1);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(INIT_EDGES - 1);

    frame_st_e         st;
    logic [CNT_W-1:0]  init_cnt;
    logic [BIT_W-1:0]  bitc;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic              last_sw;
    logic              release_q;
    logic [BYTE_W-1:0] byte_now;
    logic              last_bit;

    assign byte_now = {sw, shreg};
    assign last_bit = (bitc == LAST_BIT);
    assign wr_data  = byte_now;
    assign wr_stb   = rise && (st == F_BYTE2) && last_bit &&
                      !cmd_q.ext && cmd_q.wr && cmd_q.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= F_IDLE;
            mode      <= 1'b0;
            init_cnt  <= '0;
            bitc      <= '0;
            shreg     <= '0;
            txsh      <= '1;
            cmd_q     <= '0;
            eidx_q    <= '0;
            last_sw   <= 1'b0;
            led_blank <= 1'b0;
            det_blank <= 1'b0;
            drive     <= 1'b0;
            sbit      <= 1'b1;
            release_q <= 1'b0;
        end else if (rise) begin
            last_sw <= sw;
            case (st)
                F_IDLE: begin
                    if (!mode) begin
                        if (sw)                       init_cnt <= '0;
                        else if (init_cnt == CNT_TOP) mode     <= 1'b1;
                        else                          init_cnt <= init_cnt + 1'b1;
                    end else begin
                        st        <= F_PEND;
                        led_blank <= 1'b1;
                    end
                end
                F_PEND: begin
                    st   <= F_CMD;
                    bitc <= '0;
                end
                F_CMD: begin
                    shreg <= byte_now[BYTE_W-1:1];
                    bitc  <= bitc + 1'b1;
                    if (last_bit) begin
                        cmd_q <= decode_cmd(byte_now, DEV_ADDR);
                        st    <= F_GAP2;
                    end
                end
                F_GAP2: begin
                    bitc <= '0;
                    if (!cmd_q.wr && !cmd_q.ext) begin
                        st        <= F_RESP;
                        txsh      <= rd_data;
                        det_blank <= cmd_q.hit;
                    end else begin
                        st <= F_BYTE2;
                    end
                end
                F_BYTE2: begin
                    shreg <= byte_now[BYTE_W-1:1];
                    bitc  <= bitc + 1'b1;
                    if (last_bit) begin
                        if (cmd_q.ext) begin
                            eidx_q <= byte_now;
                            st     <= F_GAP3;
                        end else begin
                            st        <= F_IDLE;
                            led_blank <= 1'b0;
                        end
                    end
                end
                F_GAP3: begin
                    bitc <= '0;
                    if (!cmd_q.wr) begin
                        st        <= F_RESP;
                        txsh      <= rd_data;
                        det_blank <= cmd_q.hit;
                    end else begin
                        st <= F_BYTE3;
                    end
                end
                F_BYTE3: begin
                    bitc <= bitc + 1'b1;
                    if (last_bit) begin
                        st        <= F_IDLE;
                        led_blank <= 1'b0;
                    end
                end
                F_RESP: begin
                    drive <= cmd_q.hit;
                    sbit  <= txsh[0];
                    txsh  <= {1'b1, txsh[BYTE_W-1:1]};
                    if (last_sw && !sw) begin
                        st        <= F_IDLE;
                        led_blank <= 1'b0;
                        release_q <= 1'b1;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end else if (fall && release_q) begin
            drive     <= 1'b0;
            det_blank <= 1'b0;
            release_q <= 1'b0;
        end
    end

    // R1: nothing is framed before control mode is reached
    a_r1_quiet_until_mode: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (st == F_IDLE && !led_blank));

    // R2: every non-idle frame state runs with the emitter blanked
    a_r2_blank_in_frame: assert property (@(posedge clk) disable iff (rst)
        (st != F_IDLE) |-> led_blank);

    // R9: the read pin is never driven without the detector mask
    a_r9_drive_under_mask: assert property (@(posedge clk) disable iff (rst)
        drive |-> det_blank);

    // R10: an unaddressed read never drives the read pin
    a_r10_miss_silent: assert property (@(posedge clk) disable iff (rst)
        (st == F_RESP && !cmd_q.hit) |-> !drive);

    // R8: a pending release completes on the next falling edge
    a_r8_release_on_fall: assert property (@(posedge clk) disable iff (rst)
        (release_q && fall) |=> (!drive && !det_blank));

endmodule

// File: rtl/xcvr_ctl_regs.sv
module xcvr_ctl_regs
    import xcvr_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_MFR  = 8'h01,
    parameter logic [BYTE_W-1:0] ID_PROD = 8'h41
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_eidx,
    output cfg_t              cfg,
    output logic [BYTE_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.awake <= 1'b0;
            cfg.rx_en <= 1'b0;
            cfg.tx_en <= 1'b0;
            cfg.rate  <= '0;
            cfg.power <= 2'b11;
        end else if (wr_stb) begin
            case (wr_idx)
                IDX_MODE: begin
                    cfg.awake <= wr_data[0];
                    cfg.rx_en <= wr_data[1];
                    cfg.tx_en <= wr_data[2];
                end
                IDX_RATE:  cfg.rate  <= wr_data;
                IDX_POWER: cfg.power <= wr_data[BYTE_W-1 -: 2];
                default: ;
            endcase
        end
    end

    assign rd_data = read_value(cfg, wr_idx, rd_eidx, ID_MFR, ID_PROD);

    // R4: configuration moves only on a write strobe
    a_r4_stable_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(cfg));

endmodule

// File: rtl/xcvr_ctl_slave.sv
module xcvr_ctl_slave
    import xcvr_ctl_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                INIT_EDGES  = 30,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 3'b000,
    parameter logic [BYTE_W-1:0] ID_MFR      = 8'h01,
    parameter logic [BYTE_W-1:0] ID_PROD     = 8'h41
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_i,
    input  logic       txd_swdat_i,
    input  logic       det_rx_n_i,
    output logic       rxd_srdat_o,
    output logic       led_drive_o,
    output logic       led_blank_o,
    output logic       det_blank_o,
    output logic       ctl_mode_o,
    output logic       awake_o,
    output logic       rx_en_o,
    output logic       tx_en_o,
    output logic       fast_rate_o,
    output logic [1:0] power_lvl_o
);
    logic              rise, fall, sw_q;
    logic [BYTE_W-1:0] rd_data, eidx_q, wr_data;
    logic              wr_stb, mode, led_blank, det_blank, drive, sbit;
    cmd_t              cmd_q;
    cfg_t              cfg;

    xcvr_ctl_sync #(.STAGES(SYNC_STAGES), .DW(1)) u_sync (
        .clk(clk), .rst(rst), .bus_clk_i(sclk_i), .data_i(txd_swdat_i),
        .data_q(sw_q), .rise_o(rise), .fall_o(fall)
    );

    xcvr_ctl_frame #(.INIT_EDGES(INIT_EDGES), .DEV_ADDR(DEV_ADDR)) u_frame (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .sw(sw_q),
        .rd_data(rd_data), .cmd_q(cmd_q), .eidx_q(eidx_q),
        .wr_stb(wr_stb), .wr_data(wr_data), .mode(mode),
        .led_blank(led_blank), .det_blank(det_blank),
        .drive(drive), .sbit(sbit)
    );

    xcvr_ctl_regs #(.ID_MFR(ID_MFR), .ID_PROD(ID_PROD)) u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_idx(cmd_q.idx),
        .wr_data(wr_data), .rd_eidx(eidx_q), .cfg(cfg), .rd_data(rd_data)
    );

    assign rxd_srdat_o = drive ? sbit
                       : (det_blank || !cfg.rx_en || !cfg.awake) ? 1'b1
                       : det_rx_n_i;
    assign led_drive_o = txd_swdat_i & cfg.tx_en & cfg.awake & ~led_blank;
    assign led_blank_o = led_blank;
    assign det_blank_o = det_blank;
    assign ctl_mode_o  = mode;
    assign awake_o     = cfg.awake;
    assign rx_en_o     = cfg.rx_en;
    assign tx_en_o     = cfg.tx_en;
    assign fast_rate_o = cfg.rate[0];
    assign power_lvl_o = cfg.power;

    // R12: a blanked or disabled emitter never lights
    a_r12_led_dark: assert property (@(posedge clk) disable iff (rst)
        (led_blank_o || !tx_en_o || !awake_o) |-> !led_drive_o);

endmodule

// File: tb/xcvr_ctl_slave_test.sv
module xcvr_ctl_slave_test;
    localparam int CLK_NS = 10;
    localparam int HALF   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sw = 1'b0, det_n = 1'b1;
    logic rxd, led, led_blank, det_blank, mode, awake, rx_en, tx_en, fast;
    logic [1:0] pwr;

    int n_cmp = 0, n_bad = 0;
    bit started = 0, done = 0;

    // behavioural reference state
    bit         m_mode = 0, m_blank = 0, m_det = 0, m_resp_on = 0, m_resp_bit = 1, m_release = 0;
    int         m_init = 0;
    logic [2:0] m_reg0 = 3'b000;
    logic [7:0] m_reg1 = 8'h00;
    logic [1:0] m_pwr  = 2'b11;

    always #(CLK_NS/2) clk = ~clk;

    xcvr_ctl_slave uut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .txd_swdat_i(sw), .det_rx_n_i(det_n),
        .rxd_srdat_o(rxd), .led_drive_o(led), .led_blank_o(led_blank),
        .det_blank_o(det_blank), .ctl_mode_o(mode), .awake_o(awake),
        .rx_en_o(rx_en), .tx_en_o(tx_en), .fast_rate_o(fast), .power_lvl_o(pwr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_read(input logic [3:0] idx, input logic [7:0] eidx);
        case (idx)
            4'd0: return {5'b0, m_reg0};
            4'd1: return m_reg1;
            4'd2: return {m_pwr, 6'b0};
            4'hF: return (eidx == 0) ? 8'h01 : (eidx == 1) ? 8'h41 : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (started) begin
            #1;
            chk("R1 ctl_mode", {7'b0, mode}, {7'b0, m_mode});
            chk("R2 led_blank", {7'b0, led_blank}, {7'b0, m_blank});
            chk("R9 det_blank", {7'b0, det_blank}, {7'b0, m_det});
            chk("R4 mode reg", {5'b0, tx_en, rx_en, awake}, {5'b0, m_reg0});
            chk("R4 rate bit", {7'b0, fast}, {7'b0, m_reg1[0]});
            chk("R4 power", {6'b0, pwr}, {6'b0, m_pwr});
            chk("R6/R11 read pin", {7'b0, rxd},
                {7'b0, m_resp_on ? m_resp_bit :
                       ((m_det || !m_reg0[1] || !m_reg0[0]) ? 1'b1 : det_n)});
            chk("R12 emitter", {7'b0, led},
                {7'b0, sw & m_reg0[2] & m_reg0[0] & ~m_blank});
        end
    end

    task automatic rise_drv(input logic v);
        @(negedge clk); sclk = 1'b1; sw = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic hold_rest();
        repeat (HALF-3) @(posedge clk);
    endtask

    task automatic fall_drv();
        @(negedge clk); sclk = 1'b0;
        repeat (3) @(posedge clk);
        if (m_release) begin m_resp_on = 0; m_det = 0; m_release = 0; end
        hold_rest();
    endtask

    task automatic bit_out(input logic v);
        rise_drv(v); hold_rest(); fall_drv();
    endtask

    task automatic init_bit(input logic v);
        rise_drv(v);
        if (!m_mode) begin
            if (v) m_init = 0;
            else begin m_init++; if (m_init == 30) m_mode = 1; end
        end
        hold_rest(); fall_drv();
    endtask

    // response phase: start cycle, 8 driven bits, end marker high-high-low (R8)
    task automatic read_phase(input bit hit, input logic [7:0] exp, input string req);
        logic [7:0] got;
        rise_drv(1'b0);
        if (hit) m_det = 1;
        hold_rest(); fall_drv();
        for (int k = 0; k < 8; k++) begin
            rise_drv(k == 5 || k == 6);
            if (hit) begin m_resp_on = 1; m_resp_bit = exp[k]; end
            if (k == 7) begin m_blank = 0; m_release = 1; end
            @(negedge clk); #1; got[k] = rxd;
            hold_rest(); fall_drv();
        end
        if (hit) chk(req, got, exp);
    endtask

    // one complete bus transaction (R2, R3): announce, start, bytes
    task automatic xact(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                        input string req);
        bit wr, ext, hit;
        wr  = b1[7];
        ext = (b1[6:3] == 4'hF);
        hit = (b1[2:0] == 3'b000);
        rise_drv(1'b0); m_blank = 1; hold_rest(); fall_drv();
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(b1[i]);
        if (!wr && !ext) begin
            read_phase(hit, ref_read(b1[6:3], 8'h00), req);
        end else begin
            bit_out(1'b0);
            if (!ext) begin
                for (int i = 0; i < 7; i++) bit_out(b2[i]);
                rise_drv(b2[7]);
                if (hit) begin
                    case (b1[6:3])
                        4'd0: m_reg0 = b2[2:0];
                        4'd1: m_reg1 = b2;
                        4'd2: m_pwr  = b2[7:6];
                        default: ;
                    endcase
                end
                m_blank = 0;
                hold_rest(); fall_drv();
            end else begin
                for (int i = 0; i < 8; i++) bit_out(b2[i]);
                if (!wr) begin
                    read_phase(hit, ref_read(4'hF, b2), req);
                end else begin
                    bit_out(1'b0);
                    for (int i = 0; i < 7; i++) bit_out(b3[i]);
                    rise_drv(b3[7]); m_blank = 0; hold_rest(); fall_drv();
                end
            end
        end
        sw = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic idle_wiggle();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); sw = i[0]; det_n = ~i[1];
        end
        @(negedge clk); sw = 1'b0; det_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        repeat (2) @(posedge clk);
        started = 1;
        @(negedge clk); #2;
        // R5: reset state
        chk("R5 mode reg", {5'b0, tx_en, rx_en, awake}, 8'h00);
        chk("R5 rate", {7'b0, fast}, 8'h00);
        chk("R5 power", {6'b0, pwr}, 8'h03);
        chk("R5 ctl_mode", {7'b0, mode}, 8'h00);

        // R1: 29 lows, a high resets, then 30 lows
        for (int i = 0; i < 29; i++) init_bit(1'b0);
        chk("R1 not yet", {7'b0, mode}, 8'h00);
        init_bit(1'b1);
        for (int i = 0; i < 29; i++) init_bit(1'b0);
        chk("R1 restarted count", {7'b0, mode}, 8'h00);
        init_bit(1'b0);
        chk("R1 entered", {7'b0, mode}, 8'h01);

        // R6 reset readbacks, R3 bit layout
        xact(8'h10, 8'h00, 8'h00, "R6 read power idx2");
        xact(8'h00, 8'h00, 8'h00, "R6 read mode idx0");
        // R7 identity via extended index
        xact(8'h78, 8'h00, 8'h00, "R7 id mfr");
        xact(8'h78, 8'h01, 8'h00, "R7 id prod");
        xact(8'h78, 8'h05, 8'h00, "R7 id other");
        // R4 writes
        xact(8'h80, 8'h07, 8'h00, "R4 write mode");
        xact(8'h88, 8'hA5, 8'h00, "R4 write rate");
        xact(8'h90, 8'h40, 8'h00, "R4 write power");
        xact(8'h08, 8'h00, 8'h00, "R6 read rate");
        xact(8'h10, 8'h00, 8'h00, "R6 read power 25");
        xact(8'h00, 8'h00, 8'h00, "R6 read mode 7");
        // R10 unaddressed write and read (detector low shows pass-through, R11)
        xact(8'h83, 8'h00, 8'h00, "R10 miss write");
        det_n = 1'b0;
        xact(8'h15, 8'h00, 8'h00, "R10 miss read");
        det_n = 1'b1;
        xact(8'h00, 8'h00, 8'h00, "R10 mode kept");
        // R4 unused index and R7 extended write change nothing
        xact(8'hA8, 8'hFF, 8'h00, "R4 unused idx");
        xact(8'hF8, 8'h00, 8'hFF, "R7 ext write");
        xact(8'h00, 8'h00, 8'h00, "R7 mode kept");
        // R11/R12 idle pass-through with everything enabled
        idle_wiggle();
        // R11 receive disabled, R12 asleep
        xact(8'h80, 8'h05, 8'h00, "R11 rx off");
        idle_wiggle();
        xact(8'h80, 8'h06, 8'h00, "R12 asleep");
        idle_wiggle();
        // R8 read after sleep write, mask released on falling edge
        xact(8'h00, 8'h00, 8'h00, "R8 read and release");
        chk("R8 mask released", {7'b0, det_blank}, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule